// File: doc/BRIEF.md
# Byte-wide peripheral register bank

This block models a row of sixteen small peripherals that a processor reaches through ordinary memory accesses. Each peripheral is fixed at configuration time as either a source of bytes (input) or a sink of bytes (output). Each one occupies a single 16-bit word at word addresses 0 to 15. The low byte of the word is a status byte and the high byte is a data byte. Input bytes arrive on an event port that carries a device number. Processor accesses arrive on a simple bus with byte enables, and read data comes back one cycle later.

For an input device, an arriving byte is latched and the device is marked as holding data. If an earlier byte has not been consumed yet, an overflow is flagged. Reading the data byte consumes the byte and clears both marks. For an output device, a write to the data byte makes the device busy. A per-device countdown, loaded with that device's processing time, then runs on the instruction tick until the device is ready again. Whenever the data/ready flag of a device changes, a one-cycle strobe goes to the interrupt controller. The full status of every device is also presented in parallel.

Top module: `iodev_bank`

## Requirements
- R1: After reset, every status byte is zero except the direction bit and, for output devices only, the data/ready bit. All strobes are low and the read data is zero.
- R2: The status byte has interrupt-enable at bit 0, direction at bit 1 (1 = input, 0 = output), data/ready at bit 2 and overflow at bit 3. Bits 7..4 read as 0. A read returns {data byte, status byte} on `bus_rdata` in the cycle after the request, and returns 0 in cycles with no read.
- R3: A byte arriving for an input device is stored, and the data/ready bit is set in the next cycle. If that bit was already set and no data read happens in the same cycle, the overflow bit is also set.
- R4: A read of an input device with byte enable 1 set clears its data/ready and overflow bits, and leaves the data byte unchanged. A read with only byte enable 0 set changes nothing.
- R5: A write with byte enable 1 to an output device stores `bus_wdata[15:8]`, clears its data/ready bit and loads its countdown with that device's processing time.
- R6: While an output device is busy, each cycle with `tick` high decrements its countdown. The data/ready bit is set again on the tick that finds the count at 1 or 0, so a processing time of 0 or 1 takes one tick. A tick in the same cycle as a write has no effect on that device.
- R7: Data writes to input devices, arrivals for output devices, and any bus access at word address 16 or above are ignored. A read at such an address returns 0.
- R8: A write with byte enable 0 to any device sets its interrupt-enable bit from `bus_wdata[0]`.
- R9: `chg_strobe[i]` is high for exactly the cycles in which device i's data/ready bit shows a value different from the cycle before.
- R10: When a data read and a new arrival hit the same input device in one cycle, the read returns the old byte. Afterwards the device holds the new byte, with data/ready set and overflow clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_is_input | input | NDEV | Per-device direction, 1 = input |
| cfg_proc_time | input | NDEV*CNT_W | Per-device processing time in ticks |
| in_valid | input | 1 | Input byte arrival event |
| in_dev | input | IW | Device number of the arrival |
| in_data | input | 8 | Arriving byte |
| tick | input | 1 | One pulse per executed instruction |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 2 | Byte enables: bit 0 status byte, bit 1 data byte |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| dev_status | output | NDEV*8 | All status bytes, device i at [8i+7:8i] |
| chg_strobe | output | NDEV | Per-device data/ready change strobe |

## Verification
The bench builds the block with sixteen devices and an 8-bit countdown. It uses processing times from 0 to 6, so the short-count corner (0 and 1 both taking one tick) and a full busy-to-ready cycle both occur within a few ticks. Input and output devices are interleaved in the direction mask. Random arrivals therefore also land on output devices, and random addresses run up to 40, which reaches the ignored range above word 15. Directed steps place a read and an arrival in the same cycle and set up back-to-back arrivals, which exercises the overflow ordering.

// File: rtl/iodev_pkg.sv
`timescale 1ns/1ps
package iodev_pkg;
  localparam int ST_IE  = 0;
  localparam int ST_IO  = 1;
  localparam int ST_RDY = 2;
  localparam int ST_OVF = 3;

  function automatic logic [7:0] mk_status(input logic ie, input logic io,
                                           input logic rdy, input logic ovf);
    logic [7:0] s;
    s = 8'h00;
    s[ST_IE]  = ie;
    s[ST_IO]  = io;
    s[ST_RDY] = rdy;
    s[ST_OVF] = ovf;
    return s;
  endfunction
endpackage

// File: rtl/iodev_slot.sv
`timescale 1ns/1ps
module iodev_slot
  import iodev_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_input,
  input  logic [CNT_W-1:0] proc_time,
  input  logic             arrive,
  input  logic [7:0]       arrive_data,
  input  logic             rd_data_hit,
  input  logic             wr_data_hit,
  input  logic             wr_stat_hit,
  input  logic [7:0]       wbyte_hi,
  input  logic [7:0]       wbyte_lo,
  input  logic             tick,
  output logic [7:0]       status,
  output logic [7:0]       data,
  output logic             strobe
);
  logic             ie_q, rdy_q, ovf_q;
  logic             ie_d, rdy_d, ovf_d;
  logic [7:0]       data_q, data_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             unused_lo;

  assign unused_lo = ^wbyte_lo[7:1];

  always_comb begin
    ie_d   = ie_q;
    rdy_d  = rdy_q;
    ovf_d  = ovf_q;
    data_d = data_q;
    cnt_d  = cnt_q;
    if (wr_stat_hit) ie_d = wbyte_lo[0];
    if (is_input) begin
      if (rd_data_hit) begin
        rdy_d = 1'b0;
        ovf_d = 1'b0;
      end
      if (arrive) begin
        if (rdy_q && !rd_data_hit) ovf_d = 1'b1;
        data_d = arrive_data;
        rdy_d  = 1'b1;
      end
    end else begin
      if (wr_data_hit) begin
        data_d = wbyte_hi;
        rdy_d  = 1'b0;
        cnt_d  = proc_time;
      end else if (tick && !rdy_q) begin
        if (cnt_q <= CNT_W'(1)) begin
          rdy_d = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      rdy_q  <= ~is_input;
      ovf_q  <= 1'b0;
      data_q <= 8'h00;
      cnt_q  <= '0;
      strobe <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      rdy_q  <= rdy_d;
      ovf_q  <= ovf_d;
      data_q <= data_d;
      cnt_q  <= cnt_d;
      strobe <= (rdy_d != rdy_q);
    end
  end

  assign status = mk_status(ie_q, is_input, rdy_q, ovf_q);
  assign data   = data_q;

  // R3: arrival on an input device latches the byte and marks data present
  p_arrive_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (is_input && arrive) |=> (rdy_q && data_q == $past(arrive_data)));

  // R3: overflow is only ever raised while data is present
  p_ovf_needs_rdy_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> rdy_q);

  // R4: a consuming read with no arrival clears both flags, data kept
  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (is_input && rd_data_hit && !arrive) |=>
      (!rdy_q && !ovf_q && $stable(data_q)));

  // R5: a data write to an output device makes it busy
  p_write_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (!is_input && wr_data_hit) |=> (!rdy_q && data_q == $past(wbyte_hi)));

  // R6: without a tick a busy output device stays busy
  p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!is_input && !rdy_q && !tick && !wr_data_hit) |=> !rdy_q);

  // R9: the strobe marks a change of the ready bit
  p_strobe_change_r9: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (rdy_q != $past(rdy_q)));
endmodule

// File: rtl/iodev_rdmux.sv
`timescale 1ns/1ps
module iodev_rdmux #(
  parameter int NDEV = 16,
  parameter int IW   = $clog2(NDEV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [IW-1:0]     rd_idx,
  input  logic [NDEV*8-1:0] stat_flat,
  input  logic [NDEV*8-1:0] data_flat,
  output logic [15:0]       rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 16'h0000;
    end else if (rd_req) begin
      rdata <= {data_flat[rd_idx*8 +: 8], stat_flat[rd_idx*8 +: 8]};
    end else begin
      rdata <= 16'h0000;
    end
  end

  // R2: idle read port returns zero
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (rdata == 16'h0000));

  // R2: upper status nibble of a returned word is always zero
  p_upper_nib_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> (rdata[7:4] == 4'h0));
endmodule

// File: rtl/iodev_bank.sv
`timescale 1ns/1ps
module iodev_bank #(
  parameter int NDEV  = 16,
  parameter int AW    = 16,
  parameter int CNT_W = 16,
  localparam int IW   = $clog2(NDEV)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NDEV-1:0]       cfg_is_input,
  input  logic [NDEV*CNT_W-1:0] cfg_proc_time,
  input  logic                  in_valid,
  input  logic [IW-1:0]         in_dev,
  input  logic [7:0]            in_data,
  input  logic                  tick,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [1:0]            bus_be,
  input  logic [AW-1:0]         bus_addr,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  output logic [NDEV*8-1:0]     dev_status,
  output logic [NDEV-1:0]       chg_strobe
);
  logic              in_range;
  logic [IW-1:0]     idx;
  logic [NDEV*8-1:0] data_flat;

  assign in_range = bus_en && (bus_addr < AW'(NDEV));
  assign idx      = bus_addr[IW-1:0];

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    logic sel;
    assign sel = in_range && (idx == IW'(i));

    iodev_slot #(.CNT_W(CNT_W)) u_slot (
      .clk         (clk),
      .rst         (rst),
      .is_input    (cfg_is_input[i]),
      .proc_time   (cfg_proc_time[i*CNT_W +: CNT_W]),
      .arrive      (in_valid && (in_dev == IW'(i))),
      .arrive_data (in_data),
      .rd_data_hit (sel && !bus_we && bus_be[1]),
      .wr_data_hit (sel && bus_we && bus_be[1]),
      .wr_stat_hit (sel && bus_we && bus_be[0]),
      .wbyte_hi    (bus_wdata[15:8]),
      .wbyte_lo    (bus_wdata[7:0]),
      .tick        (tick),
      .status      (dev_status[i*8 +: 8]),
      .data        (data_flat[i*8 +: 8]),
      .strobe      (chg_strobe[i])
    );
  end

  iodev_rdmux #(.NDEV(NDEV), .IW(IW)) u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (in_range && !bus_we),
    .rd_idx    (idx),
    .stat_flat (dev_status),
    .data_flat (data_flat),
    .rdata     (bus_rdata)
  );

  // R7: an access outside the device window never returns data
  p_out_of_range_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_addr >= AW'(NDEV)) |=> (bus_rdata == 16'h0000));
endmodule

// File: tb/sim_iodev_bank.sv
`timescale 1ns/1ps
module sim_iodev_bank;
  localparam int N  = 16;
  localparam int CW = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] cfg_is_input;
  logic [N*CW-1:0] cfg_proc_time;
  logic in_valid, tick, bus_en, bus_we;
  logic [3:0] in_dev;
  logic [7:0] in_data;
  logic [1:0] bus_be;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [N*8-1:0] dev_status;
  logic [N-1:0] chg_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_ie[N], m_rdy[N], m_ovf[N];
  logic [7:0] m_data[N];
  int m_cnt[N];
  int pt[N];

  always #4 clk = ~clk;

  iodev_bank #(.NDEV(N), .AW(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .cfg_is_input(cfg_is_input), .cfg_proc_time(cfg_proc_time),
    .in_valid(in_valid), .in_dev(in_dev), .in_data(in_data), .tick(tick),
    .bus_en(bus_en), .bus_we(bus_we), .bus_be(bus_be), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_status(dev_status),
    .chg_strobe(chg_strobe));

  function automatic logic [7:0] st_of(int i);
    return {4'h0, m_ovf[i], m_rdy[i], cfg_is_input[i], m_ie[i]};
  endfunction

  function automatic logic [N*8-1:0] all_status();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = st_of(i);
    return v;
  endfunction

  task automatic check(string tag, string what, logic [N*8-1:0] got, logic [N*8-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(bit v, int dev, logic [7:0] d, bit en, bit we, logic [1:0] be,
                      int addr, logic [15:0] wd, bit tk, string tag);
    logic [15:0] exp_rd;
    logic [N-1:0] exp_stb;
    bit n_ie[N], n_rdy[N], n_ovf[N];
    logic [7:0] n_data[N];
    int n_cnt[N];
    @(negedge clk);
    in_valid = v; in_dev = dev[3:0]; in_data = d; tick = tk;
    bus_en = en; bus_we = we; bus_be = be; bus_addr = AW'(addr); bus_wdata = wd;
    exp_rd = (en && !we && addr < N) ? {m_data[addr], st_of(addr)} : 16'h0000;
    for (int i = 0; i < N; i++) begin
      bit sel, rd, wr, ws, ar;
      sel = en && addr < N && addr == i;
      rd = sel && !we && be[1];
      wr = sel && we && be[1];
      ws = sel && we && be[0];
      ar = v && dev == i;
      n_ie[i] = m_ie[i]; n_rdy[i] = m_rdy[i]; n_ovf[i] = m_ovf[i];
      n_data[i] = m_data[i]; n_cnt[i] = m_cnt[i];
      if (ws) n_ie[i] = wd[0];
      if (cfg_is_input[i]) begin
        if (rd) begin n_rdy[i] = 0; n_ovf[i] = 0; end
        if (ar) begin
          if (m_rdy[i] && !rd) n_ovf[i] = 1;
          n_data[i] = d; n_rdy[i] = 1;
        end
      end else begin
        if (wr) begin n_data[i] = wd[15:8]; n_rdy[i] = 0; n_cnt[i] = pt[i]; end
        else if (tk && !m_rdy[i]) begin
          if (m_cnt[i] <= 1) begin n_rdy[i] = 1; n_cnt[i] = 0; end
          else n_cnt[i] = m_cnt[i] - 1;
        end
      end
      exp_stb[i] = n_rdy[i] != m_rdy[i];
    end
    for (int i = 0; i < N; i++) begin
      m_ie[i] = n_ie[i]; m_rdy[i] = n_rdy[i]; m_ovf[i] = n_ovf[i];
      m_data[i] = n_data[i]; m_cnt[i] = n_cnt[i];
    end
    @(posedge clk);
    #1;
    check(tag, "status", dev_status, all_status());
    check("R9", "strobe", (N*8)'(chg_strobe), (N*8)'(exp_stb));
    check("R2", "rdata", (N*8)'(bus_rdata), (N*8)'(exp_rd));
  endtask

  task automatic idle(string tag);
    step(0, 0, 8'h00, 0, 0, 2'b00, 0, 16'h0000, 0, tag);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfg_is_input = 16'b1001_0001_0010_1001;
    for (int i = 0; i < N; i++) begin
      pt[i] = (i * 3) % 7;
      cfg_proc_time[i*CW +: CW] = CW'(pt[i]);
    end
    rst = 1; in_valid = 0; in_dev = 0; in_data = 0; tick = 0;
    bus_en = 0; bus_we = 0; bus_be = 0; bus_addr = 0; bus_wdata = 0;
    for (int i = 0; i < N; i++) begin
      m_ie[i] = 0; m_rdy[i] = !cfg_is_input[i]; m_ovf[i] = 0; m_data[i] = 0; m_cnt[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset status", dev_status, all_status());
    check("R1", "reset strobe", (N*8)'(chg_strobe), '0);
    check("R1", "reset rdata", (N*8)'(bus_rdata), '0);
    @(negedge clk); rst = 0;
    idle("R1");

    // R3 arrival then second arrival overflows (dev 0 is input)
    step(1, 0, 8'h41, 0, 0, 2'b00, 0, 0, 0, "R3");
    step(1, 0, 8'h58, 0, 0, 2'b00, 0, 0, 0, "R3");
    // R4 status-only read does not clear; data read does
    step(0, 0, 0, 1, 0, 2'b01, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 0, 2'b11, 0, 0, 0, "R4");
    // R10 simultaneous read and arrival
    step(1, 3, 8'h62, 0, 0, 2'b00, 0, 0, 0, "R10");
    step(1, 3, 8'h33, 1, 0, 2'b10, 3, 0, 0, "R10");
    step(0, 0, 0, 1, 0, 2'b10, 3, 0, 0, "R10");
    // R5/R6: dev 1 (pt=3) write, tick on write cycle ignored, then ticks
    step(0, 0, 0, 1, 1, 2'b10, 1, 16'hA500, 1, "R5");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 2'b00, 0, 0, k != 1, "R6");
    // R6 processing time 0 (dev 14) takes one tick
    step(0, 0, 0, 1, 1, 2'b10, 14, 16'h7700, 0, "R6");
    step(0, 0, 0, 0, 0, 2'b00, 0, 0, 1, "R6");
    // R7 ignored accesses
    step(0, 0, 0, 1, 1, 2'b10, 0, 16'hEE00, 0, "R7");
    step(1, 1, 8'h99, 1, 0, 2'b10, 1, 0, 0, "R7");
    step(0, 0, 0, 1, 1, 2'b11, 20, 16'hFFFF, 1, "R7");
    step(0, 0, 0, 1, 0, 2'b11, 37, 0, 0, "R7");
    // R8 interrupt-enable writes
    step(0, 0, 0, 1, 1, 2'b01, 5, 16'h0001, 0, "R8");
    step(0, 0, 0, 1, 1, 2'b01, 2, 16'h00FF, 0, "R8");
    step(0, 0, 0, 1, 1, 2'b01, 5, 16'h0000, 0, "R8");

    void'($urandom(32'd20240611));
    for (int k = 0; k < 4000; k++) begin
      int a;
      a = ($urandom % 8 == 0) ? 16 + ($urandom % 25) : $urandom % N;
      step($urandom % 3 == 0, $urandom % N, 8'($urandom), $urandom % 2 == 0,
           $urandom % 2 == 0, 2'($urandom), a, 16'($urandom), $urandom % 2 == 0, "random");
    end
    idle("random");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule